// File: doc/BRIEF.md
# Tri-State Walking-One Pin Driver

This block is a serial-loaded register that controls a bank of test-harness pins. Each stored bit maps to one pin. A stored one drives its pin high. A stored zero lets its pin float at high impedance rather than pulling it low. The intended use is to walk a single one through the chain, so that exactly one harness pin is driven at a time.

The register core uses two-state logic only. It presents a value vector and an output-enable vector per pin. The high-impedance buffers exist only in the top wrapper, which drives the physical pins. A serial output taken from the last stage lets several devices share one clock and one shift enable and behave as a single longer chain.

The asynchronous reset input is active low. It clears the chain at once. Its release passes through a two-stage synchronizer before the core leaves reset.

Top module: `twst_walk_driver`

## Requirements
- R1: While reset is asserted, and directly after it, every output enable is 0, every value bit is 0, the serial output is 0 and no pin is driven.
- R2: On a rising clock edge with shift enable high, each stored bit moves one position toward the MSB (index WIDTH-1), and the serial input is stored at index 0.
- R3: On a rising clock edge with shift enable low, the stored contents do not change.
- R4: The output-enable vector equals the stored bits. The value vector is 1 at every position whose enable is 1 and 0 at every other position.
- R5: The serial output always equals the stored MSB. Because of this, the next device in a cascade captures the MSB as it was before the shift.
- R6: Two instances joined serial output to serial input, sharing clock and shift enable, behave as one chain whose length is the sum of the two lengths.
- R7: Asserting rst_n low clears the chain without waiting for a clock edge. After rst_n rises, shifts on the first two rising edges are ignored. The third rising edge is the first that shifts.
- R8: Loading a single 1 followed by zeros places that 1 at index k-1 after k shifts, with all other enables 0.
- R9: A pin whose enable is 1 is driven to logic 1 on the pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| shift_en | input | 1 | Shift enable |
| ser_i | input | 1 | Serial data entering index 0 |
| pin_o | output | WIDTH | Harness pins: driven 1 or high impedance |
| pin_val_o | output | WIDTH | Two-state pin value |
| pin_oe_o | output | WIDTH | Per-pin output enable |
| ser_o | output | 1 | Serial output (MSB) for cascading |

## Verification
The bench walks a single one across a 30-bit instance cascaded into a second one. It checks the crossing at the boundary between the two devices. A design whose serial output ran one stage ahead or behind would show the one skipped or duplicated in the second device.

Stretches with shift enable low appear inside the stimulus. A design that shifted anyway would move the pattern out of step with the bench's model.

Reset is asserted between clock edges and checked immediately, which catches a reset that waits for a clock. Shifts are also requested in the two edges right after release. A design without the release synchronizer would take those shifts early.

// File: rtl/twst_pkg.sv
package twst_pkg;
  localparam int unsigned TWST_DEF_WIDTH = 30;
  localparam int unsigned TWST_SYNC_STAGES = 2;
endpackage

// File: rtl/twst_rst_sync.sv
module twst_rst_sync #(
  parameter int unsigned STAGES = twst_pkg::TWST_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

  AST_SYNC_LOW_WITH_INPUT: assert property (@(posedge clk) !rst_n |-> !rst_n_sync) // R7
    else $error("synchronized reset released while rst_n low");
endmodule

// File: rtl/twst_shift_core.sv
module twst_shift_core #(
  parameter int unsigned WIDTH = twst_pkg::TWST_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_i,
  output logic [WIDTH-1:0] bits_o
);
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] bits_d;

  always_comb begin
    bits_d = bits_q;
    if (shift_en) bits_d = {bits_q[WIDTH-2:0], ser_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bits_q)) // R3
    else $error("contents changed without shift enable");
  AST_SERIAL_ENTERS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bits_q[0] == $past(ser_i)) // R2
    else $error("serial input not captured at index 0");
  AST_MOVE_TOWARD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bits_q[WIDTH-1:1] == $past(bits_q[WIDTH-2:0])) // R2
    else $error("contents did not advance toward MSB");
endmodule

// File: rtl/twst_pin_map.sv
module twst_pin_map #(
  parameter int unsigned WIDTH = twst_pkg::TWST_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic [WIDTH-1:0] val_o,
  output logic [WIDTH-1:0] oe_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    always_comb begin
      oe_o[g]  = bits_i[g];
      val_o[g] = bits_i[g] ? 1'b1 : 1'b0;
    end
  end

  always_comb begin
    AST_VALUE_ONLY_WHERE_ENABLED: assert ((val_o & ~oe_o) == '0) // R4
      else $error("value set on disabled pin");
  end
endmodule

// File: rtl/twst_walk_driver.sv
module twst_walk_driver #(
  parameter int unsigned WIDTH = twst_pkg::TWST_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_i,
  output wire  [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_val_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic             ser_o
);
  logic             core_rst_n;
  logic [WIDTH-1:0] bits;

  twst_rst_sync #(.STAGES(twst_pkg::TWST_SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n)
  );

  twst_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(core_rst_n), .shift_en(shift_en), .ser_i(ser_i), .bits_o(bits)
  );

  twst_pin_map #(.WIDTH(WIDTH)) u_map (
    .bits_i(bits), .val_o(pin_val_o), .oe_o(pin_oe_o)
  );

  assign ser_o = bits[WIDTH-1];

  for (genvar g = 0; g < WIDTH; g++) begin : g_tri
    assign pin_o[g] = pin_oe_o[g] ? pin_val_o[g] : 1'bz;
  end

  AST_SERIAL_OUT_IS_MSB: assert property (@(posedge clk) disable iff (!core_rst_n)
    shift_en |=> ser_o == $past(bits[WIDTH-2])) // R5
    else $error("serial output does not follow MSB");
  AST_CLEAR_IN_RESET: assert property (@(posedge clk)
    !core_rst_n |-> (pin_oe_o == '0 && !ser_o)) // R1
    else $error("outputs active during reset");
endmodule

// File: tb/twst_walk_driver_test.sv
`timescale 1ns/1ps
module twst_walk_driver_test;
  localparam int W = 30;
  localparam int NSTIM = 16;
  // each entry: {shift_en, ser_i}
  localparam logic [1:0] STIM [NSTIM] = '{
    2'b11, 2'b10, 2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b00,
    2'b10, 2'b01, 2'b11, 2'b10, 2'b00, 2'b10, 2'b11, 2'b10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic ser_i = 1'b0;
  wire  [W-1:0] pin_a, pin_b;
  logic [W-1:0] val_a, oe_a, val_b, oe_b;
  logic so_a, so_b;
  logic [2*W-1:0] model;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  twst_walk_driver #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_i(ser_i),
    .pin_o(pin_a), .pin_val_o(val_a), .pin_oe_o(oe_a), .ser_o(so_a));
  twst_walk_driver #(.WIDTH(W)) casc (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_i(so_a),
    .pin_o(pin_b), .pin_val_o(val_b), .pin_oe_o(oe_b), .ser_o(so_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " oe"}, {34'd0, oe_a}, {34'd0, model[W-1:0]});
    chk({req, " val"}, {34'd0, val_a}, {34'd0, model[W-1:0]});
    chk({req, " casc oe"}, {34'd0, oe_b}, {34'd0, model[2*W-1:W]});
    chk({req, " ser_o"}, {63'd0, so_a}, {63'd0, model[W-1]});
    chk({req, " pins"}, {34'd0, pin_a & oe_a}, {34'd0, oe_a});
  endtask

  task automatic step(input logic en, input logic d);
    shift_en = en; ser_i = d;
    @(posedge clk);
    if (en) model = {model[2*W-2:0], d};
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    // table walk: mixes shifting and holding (R2, R3, R4, R5)
    for (int i = 0; i < NSTIM; i++) begin
      step(STIM[i][1], STIM[i][0]);
      check_all(STIM[i][1] ? "R2" : "R3");
    end
    // walking one across the cascade (R8, R6, R9)
    rst_n = 1'b0; #1;
    model = '0;
    check_all("R7");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 1'b1);
    for (int k = 2; k <= 2 * W; k++) begin
      step(1'b1, 1'b0);
      if (k == 10 || k == W) check_all("R8");
      if (k == W + 1 || k == W + 15 || k == 2 * W) check_all("R6");
    end
    chk("R6 casc ser_o", {63'd0, so_b}, 64'd1);
    chk("R9 pin driven", {63'd0, pin_b[W-1]}, 64'd1);
    step(1'b1, 1'b0);
    check_all("R8");
    // async reset between edges, then synchronized release (R7)
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    #2 rst_n = 1'b0; #1;
    model = '0;
    check_all("R7");
    @(negedge clk);
    shift_en = 1'b1; ser_i = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 edge1 ignored", {34'd0, oe_a}, 64'd0);
    @(negedge clk);
    chk("R7 edge2 ignored", {34'd0, oe_a}, 64'd0);
    @(negedge clk);
    chk("R7 edge3 shifts", {34'd0, oe_a}, 64'd1);
    shift_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule